// File: doc/BRIEF.md
# Supply Supervisor and Shutdown Controller

This block decides which sections of a switching-regulator controller are powered and allowed to run. Each clock it may receive a digitised supply sample, an unsigned millivolt code that is accepted only when its strobe is high. It tracks the supply with a two-threshold undervoltage lockout. The supply becomes good at or above the upper threshold and stays good until a sample drops below the lower threshold.

That supply state is combined with three logic requests: sleep, run and auxiliary-enable. Sleep takes every section down. When run is low, the reference and the auxiliary amplifier stay up, but the oscillator, the output drivers and the error-amplifier output are shut down. Auxiliary-enable gates only the auxiliary amplifier output. A soft-start clamp forces zero duty whenever the drivers may not switch.

All outputs are registered. Each one reflects the inputs and the strobed sample that were present at the preceding rising clock edge.

Top module: `supply_supervisor`

## Requirements
- R1: A strobed sample of 4100 mV or more makes the supply good. 4100 qualifies and 4099 does not.
- R2: A strobed sample below 3500 mV makes the supply not good. 3500 keeps a good supply good. A sample between the two thresholds leaves the supply state as it was.
- R3: When `vdd_stb` is 0, `vdd_mv` has no effect on the supply state or on any output.
- R4: `pwr_good` is 1 exactly when the supply is good and `sleep_req` is 0.
- R5: When `sleep_req` is 1, `pwr_good`, `ref_on`, `drive_en`, `ea_en` and `aux_en` are all 0 and `soft_clamp` is 1, whatever the other inputs are.
- R6: With `sleep_req` at 0, `ref_on` is 1, and `ea_en` is 1 exactly when `run_req` is 1 and the supply is good. `run_req` at 0 leaves `ref_on` and `pwr_good` unaffected.
- R7: With `sleep_req` at 0, `aux_en` equals `aux_req`, independent of `run_req` and of the supply state.
- R8: `soft_clamp` is 1 exactly when `sleep_req` is 1, `run_req` is 0, or the supply is not good.
- R9: `drive_en` is 1 exactly when `sleep_req` is 0, `run_req` is 1 and the supply is good.
- R10: A synchronous reset makes the supply not good. The cycle after reset shows every output at 0 except `soft_clamp` at 1. Every output follows its inputs with a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_mv | input | 13 | Supply sample in millivolts |
| vdd_stb | input | 1 | Marks `vdd_mv` as a valid sample |
| sleep_req | input | 1 | Shuts down every section |
| run_req | input | 1 | Allows the oscillator, drivers and error amplifier to run |
| aux_req | input | 1 | Enables the auxiliary amplifier output |
| pwr_good | output | 1 | Supply good and not sleeping |
| ref_on | output | 1 | Reference enable |
| drive_en | output | 1 | Oscillator and output driver enable |
| ea_en | output | 1 | Error-amplifier output enable |
| aux_en | output | 1 | Auxiliary amplifier output enable |
| soft_clamp | output | 1 | Forces the soft-start node low (zero duty) |

## Verification
The bench pushes the supply across both thresholds at their exact edges: 4099 against 4100, and 3500 against 3499. It also holds samples inside the hysteresis band from both directions. A design with an off-by-one comparison, or one that uses a single threshold, would set or drop `pwr_good` one sample too early. The bench drives out-of-band values with the strobe low, so a design that ignores the strobe would change state. It sweeps sleep, run and auxiliary-enable in every combination under both supply states. This catches a sleep override that leaves the reference or auxiliary output on, an auxiliary gate that depends on run, and a clamp that fails to assert during undervoltage.

// File: rtl/supv_pkg.sv
package supv_pkg;

    localparam int MV_W_DEF  = 13;
    localparam int UP_MV_DEF = 4100;
    localparam int DN_MV_DEF = 3500;

    typedef struct packed {
        logic pg;
        logic ref_on;
        logic drive;
        logic ea;
        logic aux;
        logic clamp;
    } gate_t;

    localparam gate_t GATE_OFF = '{pg: 1'b0, ref_on: 1'b0, drive: 1'b0,
                                   ea: 1'b0, aux: 1'b0, clamp: 1'b1};

    // Shutdown hierarchy: sleep over everything, run over the power stage,
    // aux request over the auxiliary output only.
    function automatic gate_t resolve(input logic ok, input logic slp,
                                      input logic run, input logic aux);
        gate_t g;
        g.pg     = ok & ~slp;
        g.ref_on = ~slp;
        g.drive  = ok & ~slp & run;
        g.ea     = ok & ~slp & run;
        g.aux    = ~slp & aux;
        g.clamp  = slp | ~run | ~ok;
        return g;
    endfunction

endpackage

// File: rtl/uvlo_tracker.sv
module uvlo_tracker #(
    parameter int MV_W  = supv_pkg::MV_W_DEF,
    parameter int UP_MV = supv_pkg::UP_MV_DEF,
    parameter int DN_MV = supv_pkg::DN_MV_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MV_W-1:0] mv,
    input  logic            stb,
    output logic            ok_next,
    output logic            ok_q
);
    localparam logic [MV_W-1:0] UP_C = MV_W'(UP_MV);
    localparam logic [MV_W-1:0] DN_C = MV_W'(DN_MV);

    always_comb begin
        ok_next = ok_q;
        if (stb) begin
            if (mv >= UP_C)
                ok_next = 1'b1;
            else if (mv < DN_C)
                ok_next = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ok_q <= 1'b0;
        else
            ok_q <= ok_next;
    end
endmodule

// File: rtl/gate_decoder.sv
module gate_decoder (
    input  logic            ok,
    input  logic            slp,
    input  logic            run,
    input  logic            aux,
    output supv_pkg::gate_t gate
);
    always_comb gate = supv_pkg::resolve(ok, slp, run, aux);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int MV_W  = supv_pkg::MV_W_DEF,
    parameter int UP_MV = supv_pkg::UP_MV_DEF,
    parameter int DN_MV = supv_pkg::DN_MV_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [MV_W-1:0] vdd_mv,
    input  logic            vdd_stb,
    input  logic            sleep_req,
    input  logic            run_req,
    input  logic            aux_req,
    output logic            pwr_good,
    output logic            ref_on,
    output logic            drive_en,
    output logic            ea_en,
    output logic            aux_en,
    output logic            soft_clamp
);
    import supv_pkg::*;

    logic  ok_next;
    logic  ok_q;
    gate_t gate_d;
    gate_t gate_q;

    uvlo_tracker #(.MV_W(MV_W), .UP_MV(UP_MV), .DN_MV(DN_MV)) u_uvlo (
        .clk     (clk),
        .rst     (rst),
        .mv      (vdd_mv),
        .stb     (vdd_stb),
        .ok_next (ok_next),
        .ok_q    (ok_q)
    );

    gate_decoder u_dec (
        .ok   (ok_next),
        .slp  (sleep_req),
        .run  (run_req),
        .aux  (aux_req),
        .gate (gate_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= GATE_OFF;
        else
            gate_q <= gate_d;
    end

    assign pwr_good   = gate_q.pg;
    assign ref_on     = gate_q.ref_on;
    assign drive_en   = gate_q.drive;
    assign ea_en      = gate_q.ea;
    assign aux_en     = gate_q.aux;
    assign soft_clamp = gate_q.clamp;
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk #(
    parameter int MV_W  = supv_pkg::MV_W_DEF,
    parameter int UP_MV = supv_pkg::UP_MV_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic [MV_W-1:0] vdd_mv,
    input logic            vdd_stb,
    input logic            sleep_req,
    input logic            run_req,
    input logic            aux_req,
    input logic            pwr_good,
    input logic            ref_on,
    input logic            drive_en,
    input logic            ea_en,
    input logic            aux_en,
    input logic            soft_clamp
);
    localparam logic [MV_W-1:0] UP_C = MV_W'(UP_MV);

    p_pg_rise_r1: assert property (@(posedge clk) disable iff (rst)
        (vdd_stb && vdd_mv >= UP_C && !sleep_req) |=> pwr_good);

    p_no_strobe_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!vdd_stb && !sleep_req && !$past(sleep_req)) |=> $stable(pwr_good));

    p_sleep_off_r5: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (!pwr_good && !ref_on && !drive_en && !ea_en && !aux_en && soft_clamp));

    p_aux_follow_r7: assert property (@(posedge clk) disable iff (rst)
        !sleep_req |=> (aux_en == $past(aux_req)));

    p_clamp_excl_r8: assert property (@(posedge clk) disable iff (rst)
        soft_clamp != drive_en);

    p_drive_needs_pg_r9: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (pwr_good && ref_on && ea_en));

    p_run_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (!run_req && !sleep_req) |=> (!drive_en && !ea_en && ref_on));
endmodule

bind supply_supervisor supply_supervisor_chk #(.MV_W(MV_W), .UP_MV(UP_MV)) u_chk (
    .clk(clk), .rst(rst), .vdd_mv(vdd_mv), .vdd_stb(vdd_stb),
    .sleep_req(sleep_req), .run_req(run_req), .aux_req(aux_req),
    .pwr_good(pwr_good), .ref_on(ref_on), .drive_en(drive_en),
    .ea_en(ea_en), .aux_en(aux_en), .soft_clamp(soft_clamp)
);

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] vdd_mv = '0;
    logic        vdd_stb = 1'b0;
    logic        sleep_req = 1'b0;
    logic        run_req = 1'b0;
    logic        aux_req = 1'b0;
    logic pwr_good, ref_on, drive_en, ea_en, aux_en, soft_clamp;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    bit m_ok = 0;
    bit m_pg = 0, m_ref = 0, m_drv = 0, m_ea = 0, m_aux = 0, m_clamp = 1;

    always #2.5 clk = ~clk;

    supply_supervisor uut (
        .clk(clk), .rst(rst), .vdd_mv(vdd_mv), .vdd_stb(vdd_stb),
        .sleep_req(sleep_req), .run_req(run_req), .aux_req(aux_req),
        .pwr_good(pwr_good), .ref_on(ref_on), .drive_en(drive_en),
        .ea_en(ea_en), .aux_en(aux_en), .soft_clamp(soft_clamp)
    );

    task automatic cmp(input string req, input string nm, input bit act, input bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // One cycle: apply inputs (at negedge), update model at posedge, compare at next negedge.
    task automatic step(input bit r, input bit slp, input bit run, input bit ax,
                        input bit stb, input int mv);
        rst = r; sleep_req = slp; run_req = run; aux_req = ax;
        vdd_stb = stb; vdd_mv = 13'(mv);
        @(posedge clk);
        if (r) begin
            m_ok = 0;                                  // R10
            m_pg = 0; m_ref = 0; m_drv = 0; m_ea = 0; m_aux = 0; m_clamp = 1;
        end else begin
            if (stb) begin
                if (mv >= 4100) m_ok = 1;              // R1
                else if (mv < 3500) m_ok = 0;          // R2
            end                                        // R3: no strobe, no change
            m_pg    = m_ok && !slp;                    // R4
            m_ref   = !slp;                            // R5, R6
            m_drv   = m_ok && !slp && run;             // R9
            m_ea    = m_ok && !slp && run;             // R6
            m_aux   = !slp && ax;                      // R7
            m_clamp = slp || !run || !m_ok;            // R8
        end
        @(negedge clk);
        cmp("R4", "pwr_good", pwr_good, m_pg);
        cmp("R6", "ref_on", ref_on, m_ref);
        cmp("R9", "drive_en", drive_en, m_drv);
        cmp("R6", "ea_en", ea_en, m_ea);
        cmp("R7", "aux_en", aux_en, m_aux);
        cmp("R8", "soft_clamp", soft_clamp, m_clamp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: reset state
        step(1, 0, 1, 1, 1, 5000);
        step(1, 0, 1, 1, 0, 0);
        // R1: rising edge of threshold, 4099 rejected, 4100 accepted
        step(0, 0, 1, 0, 1, 3000);
        step(0, 0, 1, 0, 1, 4099);
        step(0, 0, 1, 0, 1, 4100);
        // R2: in-band and lower edge
        step(0, 0, 1, 1, 1, 3800);
        step(0, 0, 1, 1, 1, 3500);
        step(0, 0, 1, 1, 1, 3499);
        step(0, 0, 1, 1, 1, 4000);   // band from below stays bad
        // R3: out-of-band values without strobe
        step(0, 0, 1, 1, 0, 8000);
        step(0, 0, 1, 1, 1, 4500);
        step(0, 0, 1, 1, 0, 0);
        step(0, 0, 1, 1, 0, 100);
        // R5/R6/R7/R8: every request combination, supply good then bad
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 8; k++)
                step(0, k[2], k[1], k[0], 0, 0);
            step(0, 0, 1, 0, 1, 1000);
        end
        // sleep while a rising sample arrives: state still tracked (R5, R4)
        step(0, 1, 1, 1, 1, 4200);
        step(0, 0, 1, 1, 0, 0);
        // pseudo-random sweep
        for (int i = 0; i < 400; i++) begin
            int mv = 3300 + int'($urandom_range(1000));
            step(($urandom_range(40) == 0), ($urandom_range(5) == 0),
                 $urandom_range(1), $urandom_range(1), $urandom_range(1), mv);
        end
        // reset mid-run clears supply state (R10)
        step(0, 0, 1, 1, 1, 4600);
        step(1, 0, 1, 1, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule